// File: doc/BRIEF.md
# Precise Pipeline Exception Controller

This block takes exceptions for a five-stage in-order pipeline whose stages are fetch, decode, execute, memory and writeback. Each of the decode, execute and memory stages reports a valid flag, its own exception request and the address of the instruction it holds. That address travels down the pipeline with the instruction, so the saved exception address is exact. Decode reports undefined instructions. Execute reports arithmetic overflow. Memory reports a misaligned data address.

In any cycle, the block takes the exception of the oldest faulting instruction, which is the one in the deepest stage. It flushes that stage and every younger stage, and it blocks a data-memory write when the faulting instruction is in the memory stage. It also redirects fetch to a handler. The redirect, the cause load and the exception-address load all take effect at the same clock edge. The handler address is either one fixed entry point or a vector chosen by the cause code, selected by a mode pin. A build parameter covers pipelines whose stages carry the incremented address instead of the instruction's own address.

Top module: `precise_trap_unit`

## Requirements
- R1: After reset, `epc` and `cause` read zero, and with no request `redirect_valid` is 0 and `flush` is 0.
- R2: A request from a stage whose valid is low is ignored. In a cycle with no valid request, `redirect_valid`, `flush` and `mem_kill` are 0, and `epc` and `cause` keep their values.
- R3: A valid memory-stage address fault gives `flush` = 4'b1111 (bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory) and `mem_kill` = 1.
- R4: A valid execute-stage overflow with no memory fault gives `flush` = 4'b0111 and `mem_kill` = 0.
- R5: A valid decode-stage undefined instruction with no deeper fault gives `flush` = 4'b0011 and `mem_kill` = 0.
- R6: When several stages fault in one cycle, only the deepest one is taken. Its flush pattern, cause, exception address and handler are used, and the younger requests are dropped.
- R7: At the edge of a taken exception, `cause` is loaded with one bit set: bit 2 for undefined instruction, bit 4 for address fault, bit 5 for overflow. Cause codes are 2, 4 and 5.
- R8: At the same edge, `epc` is loaded with the faulting stage's PC. When `PC_PLUS4` = 1, it is loaded with that PC minus 4.
- R9: With `vec_mode` = 0, `redirect_valid` is 1 in the faulting cycle and `redirect_pc` equals `HANDLER_BASE`.
- R10: With `vec_mode` = 1, `redirect_pc` equals `VEC_BASE + code * VEC_STRIDE`, where code is the cause code of the taken exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_mode | input | 1 | 1 selects a handler vector by cause code |
| id_valid | input | 1 | Decode stage holds a live instruction |
| id_undef | input | 1 | Decode found an undefined instruction |
| id_pc | input | PC_W | PC of the decode-stage instruction |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_ovf | input | 1 | Execute raised arithmetic overflow |
| ex_pc | input | PC_W | PC of the execute-stage instruction |
| mem_valid | input | 1 | Memory stage holds a live instruction |
| mem_adr_err | input | 1 | Memory stage found a misaligned address |
| mem_pc | input | PC_W | PC of the memory-stage instruction |
| flush | output | 4 | Squash per stage: bit 0 fetch to bit 3 memory |
| mem_kill | output | 1 | Block the data-memory write this cycle |
| redirect_valid | output | 1 | Fetch must load `redirect_pc` at this edge |
| redirect_pc | output | PC_W | Handler entry address |
| epc | output | PC_W | Address of the last faulting instruction |
| cause | output | CAUSE_W | One-hot record of the last exception type |

## Verification
Faults in two or three stages can land in the same cycle, so the priority choice and the flush, cause, exception address and handler all depend on one selection at once. The bench provokes this with directed cycles in which all three stages fault, and in which execute and decode fault together. Random cycles with independent request probabilities produce many more such overlaps. A bench model picks the deepest valid fault and predicts every output from that choice. The registered `epc` and `cause` are compared after the edge, for both settings of the address-adjust parameter.

// File: rtl/trap_pkg.sv
package trap_pkg;
  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_UNDEF = 3'd2,
    EXC_ADDR  = 3'd4,
    EXC_OVF   = 3'd5
  } exc_code_e;

  localparam int N_STAGE = 4;
  localparam int ST_IF   = 0;
  localparam int ST_ID   = 1;
  localparam int ST_EX   = 2;
  localparam int ST_MEM  = 3;
endpackage

// File: rtl/trap_select.sv
module trap_select
  import trap_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                id_hit,
  input  logic                ex_hit,
  input  logic                mem_hit,
  input  logic [PC_W-1:0]     id_pc,
  input  logic [PC_W-1:0]     ex_pc,
  input  logic [PC_W-1:0]     mem_pc,
  output logic                take,
  output exc_code_e           code,
  output logic [PC_W-1:0]     pc_sel,
  output logic [N_STAGE-1:0]  flush
);
  logic [N_STAGE-1:0] owner;

  always_comb begin
    owner  = '0;
    code   = EXC_NONE;
    pc_sel = '0;
    if (mem_hit) begin
      owner[ST_MEM] = 1'b1;
      code          = EXC_ADDR;
      pc_sel        = mem_pc;
    end else if (ex_hit) begin
      owner[ST_EX] = 1'b1;
      code         = EXC_OVF;
      pc_sel       = ex_pc;
    end else if (id_hit) begin
      owner[ST_ID] = 1'b1;
      code         = EXC_UNDEF;
      pc_sel       = id_pc;
    end
  end

  assign take = |owner;

  // a stage is squashed when the owner is at that stage or deeper
  for (genvar g = 0; g < N_STAGE; g++) begin : g_flush
    assign flush[g] = |owner[N_STAGE-1:g];
  end
endmodule

// File: rtl/trap_vector.sv
module trap_vector
  import trap_pkg::*;
#(
  parameter int              PC_W         = 32,
  parameter logic [PC_W-1:0] HANDLER_BASE = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_BASE     = 32'h8000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE   = 32'h0000_0080
) (
  input  logic            vec_mode,
  input  exc_code_e       code,
  output logic [PC_W-1:0] handler
);
  logic [PC_W-1:0] vec_addr;

  assign vec_addr = VEC_BASE + PC_W'(code) * VEC_STRIDE;
  assign handler  = vec_mode ? vec_addr : HANDLER_BASE;
endmodule

// File: rtl/trap_state.sv
module trap_state
  import trap_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int CAUSE_W  = 8,
  parameter bit PC_PLUS4 = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  exc_code_e          code,
  input  logic [PC_W-1:0]    pc_sel,
  output logic [PC_W-1:0]    epc,
  output logic [CAUSE_W-1:0] cause
);
  logic [PC_W-1:0]    epc_d;
  logic [CAUSE_W-1:0] cause_d;
  logic [PC_W-1:0]    pc_fix;

  if (PC_PLUS4) begin : g_minus4
    assign pc_fix = pc_sel - PC_W'(4);
  end else begin : g_exact
    assign pc_fix = pc_sel;
  end

  always_comb begin
    epc_d   = epc;
    cause_d = cause;
    if (take) begin
      epc_d   = pc_fix;
      cause_d = CAUSE_W'(1) << code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc   <= '0;
      cause <= '0;
    end else if (take) begin
      epc   <= epc_d;
      cause <= cause_d;
    end
  end
endmodule

// File: rtl/precise_trap_unit.sv
module precise_trap_unit
  import trap_pkg::*;
#(
  parameter int              PC_W         = 32,
  parameter int              CAUSE_W      = 8,
  parameter bit              PC_PLUS4     = 1'b0,
  parameter logic [PC_W-1:0] HANDLER_BASE = 32'h8000_0180,
  parameter logic [PC_W-1:0] VEC_BASE     = 32'h8000_0000,
  parameter logic [PC_W-1:0] VEC_STRIDE   = 32'h0000_0080
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vec_mode,
  input  logic               id_valid,
  input  logic               id_undef,
  input  logic [PC_W-1:0]    id_pc,
  input  logic               ex_valid,
  input  logic               ex_ovf,
  input  logic [PC_W-1:0]    ex_pc,
  input  logic               mem_valid,
  input  logic               mem_adr_err,
  input  logic [PC_W-1:0]    mem_pc,
  output logic [3:0]         flush,
  output logic               mem_kill,
  output logic               redirect_valid,
  output logic [PC_W-1:0]    redirect_pc,
  output logic [PC_W-1:0]    epc,
  output logic [CAUSE_W-1:0] cause
);
  logic            id_hit, ex_hit, mem_hit;
  logic            take;
  exc_code_e       code;
  logic [PC_W-1:0] pc_sel;
  logic [3:0]      flush_w;

  assign id_hit  = id_valid  && id_undef;
  assign ex_hit  = ex_valid  && ex_ovf;
  assign mem_hit = mem_valid && mem_adr_err;

  trap_select #(.PC_W(PC_W)) u_sel (
    .id_hit (id_hit),
    .ex_hit (ex_hit),
    .mem_hit(mem_hit),
    .id_pc  (id_pc),
    .ex_pc  (ex_pc),
    .mem_pc (mem_pc),
    .take   (take),
    .code   (code),
    .pc_sel (pc_sel),
    .flush  (flush_w)
  );

  trap_vector #(
    .PC_W        (PC_W),
    .HANDLER_BASE(HANDLER_BASE),
    .VEC_BASE    (VEC_BASE),
    .VEC_STRIDE  (VEC_STRIDE)
  ) u_vec (
    .vec_mode(vec_mode),
    .code    (code),
    .handler (redirect_pc)
  );

  trap_state #(
    .PC_W    (PC_W),
    .CAUSE_W (CAUSE_W),
    .PC_PLUS4(PC_PLUS4)
  ) u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .code  (code),
    .pc_sel(pc_sel),
    .epc   (epc),
    .cause (cause)
  );

  assign flush          = flush_w;
  assign redirect_valid = take;
  assign mem_kill       = take && (code == EXC_ADDR);
endmodule

// File: rtl/trap_unit_checker.sv
module trap_unit_checker #(
  parameter int              PC_W         = 32,
  parameter int              CAUSE_W      = 8,
  parameter bit              PC_PLUS4     = 1'b0,
  parameter logic [PC_W-1:0] HANDLER_BASE = 32'h8000_0180
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vec_mode,
  input logic               id_valid,
  input logic               id_undef,
  input logic               ex_valid,
  input logic               ex_ovf,
  input logic               mem_valid,
  input logic               mem_adr_err,
  input logic [PC_W-1:0]    mem_pc,
  input logic [3:0]         flush,
  input logic               mem_kill,
  input logic               redirect_valid,
  input logic [PC_W-1:0]    redirect_pc,
  input logic [PC_W-1:0]    epc,
  input logic [CAUSE_W-1:0] cause
);
  localparam logic [PC_W-1:0] OFFS = PC_PLUS4 ? PC_W'(4) : '0;

  logic c_id, c_ex, c_mem;
  assign c_id  = id_valid  && id_undef;
  assign c_ex  = ex_valid  && ex_ovf;
  assign c_mem = mem_valid && mem_adr_err;

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_id || c_ex || c_mem) |-> (!redirect_valid && flush == 4'b0000 && !mem_kill));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect_valid |=> ($stable(epc) && $stable(cause)));

  p_mem_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    c_mem |-> (flush == 4'b1111 && mem_kill));

  p_ex_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ex && !c_mem) |-> (flush == 4'b0111 && !mem_kill));

  p_id_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_id && !c_ex && !c_mem) |-> (flush == 4'b0011 && !mem_kill));

  p_cause_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause));

  p_epc_mem_r8: assert property (@(posedge clk) disable iff (!rst_n)
    c_mem |=> (epc == $past(mem_pc) - OFFS));

  p_fixed_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !vec_mode) |-> (redirect_pc == HANDLER_BASE));
endmodule

bind precise_trap_unit trap_unit_checker #(
  .PC_W        (PC_W),
  .CAUSE_W     (CAUSE_W),
  .PC_PLUS4    (PC_PLUS4),
  .HANDLER_BASE(HANDLER_BASE)
) u_chk (.*);

// File: tb/sim_precise_trap_unit.sv
module sim_precise_trap_unit;
  localparam int          PC_W = 32;
  localparam logic [31:0] HB   = 32'h8000_0180;
  localparam logic [31:0] VB   = 32'h8000_0000;
  localparam logic [31:0] VS   = 32'h0000_0080;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, vec_mode;
  logic        id_valid, id_undef, ex_valid, ex_ovf, mem_valid, mem_adr_err;
  logic [31:0] id_pc, ex_pc, mem_pc;
  logic [3:0]  flush0, flush1;
  logic        kill0, kill1, rv0, rv1;
  logic [31:0] rpc0, rpc1, epc0, epc1;
  logic [7:0]  cause0, cause1;

  precise_trap_unit #(.PC_W(PC_W), .PC_PLUS4(1'b0), .HANDLER_BASE(HB),
                      .VEC_BASE(VB), .VEC_STRIDE(VS)) u0 (
    .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode),
    .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .mem_valid(mem_valid), .mem_adr_err(mem_adr_err), .mem_pc(mem_pc),
    .flush(flush0), .mem_kill(kill0), .redirect_valid(rv0),
    .redirect_pc(rpc0), .epc(epc0), .cause(cause0));

  precise_trap_unit #(.PC_W(PC_W), .PC_PLUS4(1'b1), .HANDLER_BASE(HB),
                      .VEC_BASE(VB), .VEC_STRIDE(VS)) u1 (
    .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode),
    .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
    .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
    .mem_valid(mem_valid), .mem_adr_err(mem_adr_err), .mem_pc(mem_pc),
    .flush(flush1), .mem_kill(kill1), .redirect_valid(rv1),
    .redirect_pc(rpc1), .epc(epc1), .cause(cause1));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] x_epc0, x_epc1;
  logic [7:0]  x_cause;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int f_code(logic iv, logic iu, logic ev, logic eo, logic mv, logic ma);
    if (mv && ma) return 4;
    if (ev && eo) return 5;
    if (iv && iu) return 2;
    return 0;
  endfunction

  function automatic logic [3:0] f_flush(int c);
    case (c)
      4: return 4'b1111;
      5: return 4'b0111;
      2: return 4'b0011;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] f_handler(int c, logic vm);
    return vm ? VB + 32'(c) * VS : HB;
  endfunction

  task automatic step(logic iv, logic iu, logic [31:0] ip, logic ev, logic eo,
                      logic [31:0] ep, logic mv, logic ma, logic [31:0] mp, logic vm);
    int c;
    int hits;
    string tag;
    @(negedge clk);
    id_valid = iv; id_undef = iu; id_pc = ip;
    ex_valid = ev; ex_ovf = eo; ex_pc = ep;
    mem_valid = mv; mem_adr_err = ma; mem_pc = mp; vec_mode = vm;
    #2;
    c    = f_code(iv, iu, ev, eo, mv, ma);
    hits = int'(iv && iu) + int'(ev && eo) + int'(mv && ma);
    if (hits > 1)   tag = "R6";
    else if (c == 4) tag = "R3";
    else if (c == 5) tag = "R4";
    else if (c == 2) tag = "R5";
    else             tag = "R2";
    chk({tag, " flush"}, 32'(flush0), 32'(f_flush(c)));
    chk({tag, " mem_kill"}, 32'(kill0), 32'(c == 4));
    chk({tag, " redirect_valid"}, 32'(rv0), 32'(c != 0));
    if (c != 0) begin
      chk(vm ? "R10 vector" : "R9 fixed", rpc0, f_handler(c, vm));
      x_epc0  = (c == 4) ? mp : (c == 5) ? ep : ip;
      x_epc1  = x_epc0 - 32'd4;
      x_cause = 8'd1 << c;
    end
    @(posedge clk);
    #2;
    chk(c != 0 ? "R8 epc exact" : "R2 epc hold", epc0, x_epc0);
    chk(c != 0 ? "R8 epc minus4" : "R2 epc hold", epc1, x_epc1);
    chk(c != 0 ? "R7 cause" : "R2 cause hold", 32'(cause0), 32'(x_cause));
    chk("R7 cause twin", 32'(cause1), 32'(x_cause));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R2 act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; vec_mode = 1'b0;
    id_valid = 0; id_undef = 0; id_pc = '0;
    ex_valid = 0; ex_ovf = 0; ex_pc = '0;
    mem_valid = 0; mem_adr_err = 0; mem_pc = '0;
    x_epc0 = '0; x_epc1 = '0; x_cause = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset values
    chk("R1 epc", epc0, 32'h0);
    chk("R1 cause", 32'(cause0), 32'h0);
    chk("R1 redirect_valid", 32'(rv0), 32'h0);
    chk("R1 flush", 32'(flush0), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 requests on stages that are not valid
    step(0, 1, 32'h100, 0, 1, 32'h0FC, 0, 1, 32'h0F8, 0);
    // R5 decode fault, fixed handler
    step(1, 1, 32'h0000_2000, 1, 0, 32'h1FFC, 1, 0, 32'h1FF8, 0);
    // R4 overflow, vectored
    step(1, 0, 32'h3008, 1, 1, 32'h3004, 1, 0, 32'h3000, 1);
    // R3 address fault, vectored
    step(0, 0, 32'h0, 0, 0, 32'h0, 1, 1, 32'h4444, 1);
    // R6 all three stages at once
    step(1, 1, 32'h5010, 1, 1, 32'h500C, 1, 1, 32'h5008, 0);
    step(1, 1, 32'h5010, 1, 1, 32'h500C, 1, 1, 32'h5008, 1);
    // R6 execute and decode together, memory invalid with request
    step(1, 1, 32'h6010, 1, 1, 32'h600C, 0, 1, 32'h6008, 1);
    // R10 decode fault vectored
    step(1, 1, 32'h7000, 0, 1, 32'h0, 0, 0, 32'h0, 1);
    // R2 idle cycle keeps the last record
    step(0, 0, 32'h0, 0, 0, 32'h0, 0, 0, 32'h0, 0);

    for (int k = 0; k < 500; k++) begin
      logic [31:0] base;
      base = {$urandom} & 32'hFFFF_FFFC;
      step($urandom % 2 == 0, $urandom % 4 == 0, base + 32'd8,
           $urandom % 2 == 0, $urandom % 4 == 0, base + 32'd4,
           $urandom % 2 == 0, $urandom % 5 == 0, base,
           $urandom % 2 == 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule